// File: doc/BRIEF.md
# Quasi-Bidirectional Port Bit Controller

This block holds the control logic of an eight-bit port whose pins are both outputs and inputs without a direction register. Each bit has an output latch written from a register bus. A bit whose driven level is 1 is held high only by a weak pull-up, so an outside device may pull the pin low and the bit then works as an input. A bit whose driven level is 0 turns on the pull-down. Whenever a bit's driven level rises from 0 to 1, a strong pull-up is switched on for exactly two clocks to speed the rising edge. After that only the weak pull-up stays on.

Selected bits carry alternate-function outputs, such as a serial transmit line or a memory strobe. These can pull the pin low only while the latch bit is 1. Two further bits can be handed to a pair of PWM outputs through a configuration input. While that input is set, the PWM level replaces the latch on those two pins. Register reads return either the latch contents, which suits read-modify-write instructions, or the pin levels after a two-flop synchronizer. The synchronized levels also feed the alternate-function inputs.

Top module: `quasi_port_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every latch bit reads 1, pad_wpu is all ones, pad_pd is all zeros and pad_spu is all zeros. No strong pulse follows reset.
- R2: Each bit has a driven level. pad_pd is the inverse of that level and pad_wpu is equal to it. Both update at the clock edge after the latch (or an alternate or PWM input) changes, and not at the edge that writes the latch.
- R3: When wr_en is high at a clock edge, the latch takes wr_data. With rd_sel = 0 (latch path), rd_data shows the latch contents from the cycle after the write.
- R4: With rd_sel = 1 (pin path), rd_data equals pin_sync. pin_sync equals pin_in delayed by two clock edges: one edge after a pin change the old level is still shown, and after the second edge the new level is shown.
- R5: When a bit's driven level rises from 0 to 1, pad_spu for that bit is 1 for exactly two cycles and 0 afterwards. If the level falls during the pulse, pad_spu clears in the same cycle that pad_pd turns on. pad_spu and pad_pd are never both 1 on a bit.
- R6: On the bits set in ALT_MASK (default bits 0, 1, 6 and 7), the driven level is the latch bit ANDed with alt_out of that bit. A latch 0 keeps the pin low whatever alt_out drives. On all other bits alt_out has no effect.
- R7: While pwm_sel = 1, bit PWM_BIT_A (default 3) is driven by pwm_out[0] and bit PWM_BIT_B (default 4) by pwm_out[1], and latch writes have no effect on those pins. While pwm_sel = 0, pwm_out has no effect. The latch read path always returns the latch contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Latch write strobe |
| wr_data | input | WIDTH | Value written to the latch |
| rd_sel | input | 1 | Read source: 0 selects the latch, 1 selects the synchronized pins |
| rd_data | output | WIDTH | Read data |
| alt_out | input | WIDTH | Alternate-function output levels (1 when idle) |
| pwm_sel | input | 1 | Hands PWM_BIT_A and PWM_BIT_B to the PWM outputs |
| pwm_out | input | 2 | PWM levels for PWM_BIT_A (bit 0) and PWM_BIT_B (bit 1) |
| pin_in | input | WIDTH | Pad input levels |
| pin_sync | output | WIDTH | Synchronized pin levels for alternate-function inputs |
| pad_pd | output | WIDTH | Pull-down enable per pin |
| pad_spu | output | WIDTH | Strong pull-up enable per pin |
| pad_wpu | output | WIDTH | Weak pull-up enable per pin |

## Verification
The pad is modelled as a pin that reads low when the pull-down is on or an outside device pulls it, and high otherwise. The drive logic is tried with these patterns:
- A mixed latch value, which separates the latch path from the pin path and shows the one-clock pad delay.
- An all-ones write after zeros, which measures the exact length of the strong pulse. A write sequence of 0, 1, 0 checks that the pulse is cut short at once when the level falls.
- An outside pull on a latched-1 bit, which proves the two-stage synchronizer latency.
- alt_out driven low on an alternate bit and on an ordinary bit, which shows the AND merge and the masking.
- PWM levels with zero latch bits under both settings of pwm_sel, which show the full override and the case where pwm_out has no effect.

// File: rtl/quasi_port_pkg.sv
package quasi_port_pkg;

    typedef enum logic {
        RD_LATCH = 1'b0,
        RD_PIN   = 1'b1
    } rd_src_e;

    localparam int unsigned PULSE_CYCLES_DEF = 2;

    function automatic int unsigned pulse_cnt_w(input int unsigned cycles);
        return (cycles < 2) ? 1 : $clog2(cycles + 1);
    endfunction

endpackage

// File: rtl/quasi_port_sync.sv
module quasi_port_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            st_d.stage[s] = st_q.stage[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.stage[STAGES-1];
endmodule

// File: rtl/quasi_port_latch.sv
module quasi_port_latch #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] latch
);
    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } latch_state_t;

    latch_state_t lt_d, lt_q;

    always_comb begin
        lt_d = lt_q;
        if (wr_en) begin
            lt_d.bits = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lt_q <= '{bits: '1};
        end else begin
            lt_q <= lt_d;
        end
    end

    assign latch = lt_q.bits;
endmodule

// File: rtl/quasi_port_pad_bit.sv
module quasi_port_pad_bit #(
    parameter int unsigned PULSE_CYCLES = 2,
    localparam int unsigned CNT_W = quasi_port_pkg::pulse_cnt_w(PULSE_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic pd,
    output logic spu,
    output logic wpu
);
    typedef struct packed {
        logic             drive;
        logic [CNT_W-1:0] cnt;
    } pad_state_t;

    pad_state_t ps_d, ps_q;

    always_comb begin
        ps_d = ps_q;
        ps_d.drive = level;
        if (!level) begin
            ps_d.cnt = '0;
        end else if (!ps_q.drive) begin
            ps_d.cnt = CNT_W'(PULSE_CYCLES);
        end else if (ps_q.cnt != '0) begin
            ps_d.cnt = ps_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '{drive: 1'b1, cnt: '0};
        end else begin
            ps_q <= ps_d;
        end
    end

    assign pd  = ~ps_q.drive;
    assign wpu = ps_q.drive;
    assign spu = (ps_q.cnt != '0);
endmodule

// File: rtl/quasi_port_ctrl.sv
module quasi_port_ctrl #(
    parameter int unsigned WIDTH        = 8,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned PULSE_CYCLES = quasi_port_pkg::PULSE_CYCLES_DEF,
    parameter logic [WIDTH-1:0] ALT_MASK = 8'hC3,
    parameter int unsigned PWM_BIT_A    = 3,
    parameter int unsigned PWM_BIT_B    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_sel,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] alt_out,
    input  logic             pwm_sel,
    input  logic [1:0]       pwm_out,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] pad_pd,
    output logic [WIDTH-1:0] pad_spu,
    output logic [WIDTH-1:0] pad_wpu
);
    import quasi_port_pkg::*;

    logic [WIDTH-1:0] latch;
    logic [WIDTH-1:0] level;

    quasi_port_latch #(.WIDTH(WIDTH)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .latch   (latch)
    );

    quasi_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic merged;
        if (ALT_MASK[i]) begin : g_alt
            assign merged = latch[i] & alt_out[i];
        end else begin : g_plain
            assign merged = latch[i];
        end

        if (i == PWM_BIT_A) begin : g_pwm_a
            assign level[i] = pwm_sel ? pwm_out[0] : merged;
        end else if (i == PWM_BIT_B) begin : g_pwm_b
            assign level[i] = pwm_sel ? pwm_out[1] : merged;
        end else begin : g_nopwm
            assign level[i] = merged;
        end

        quasi_port_pad_bit #(.PULSE_CYCLES(PULSE_CYCLES)) u_pad (
            .clk   (clk),
            .rst_n (rst_n),
            .level (level[i]),
            .pd    (pad_pd[i]),
            .spu   (pad_spu[i]),
            .wpu   (pad_wpu[i])
        );
    end

    assign rd_data = (rd_src_e'(rd_sel) == RD_PIN) ? pin_sync : latch;
endmodule

// File: rtl/quasi_port_chk.sv
module quasi_port_chk #(
    parameter int unsigned WIDTH     = 8,
    parameter int unsigned PWM_BIT_A = 3,
    parameter int unsigned PWM_BIT_B = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [WIDTH-1:0] wr_data,
    input logic             rd_sel,
    input logic [WIDTH-1:0] rd_data,
    input logic [WIDTH-1:0] alt_out,
    input logic             pwm_sel,
    input logic [1:0]       pwm_out,
    input logic [WIDTH-1:0] pin_in,
    input logic [WIDTH-1:0] pin_sync,
    input logic [WIDTH-1:0] pad_pd,
    input logic [WIDTH-1:0] pad_spu,
    input logic [WIDTH-1:0] pad_wpu
);
    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R5
    no_spu_with_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_spu & pad_pd) == '0);

    // R2
    pd_follows_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_sel && (&alt_out) && !rd_sel) |=> (pad_pd == ~$past(rd_data)));

    // R3
    latch_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_sel || rd_data == $past(wr_data)));

    // R4
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (pin_sync == $past(pin_in, 2)));

    // R7
    pwm_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_sel |=> (pad_pd[PWM_BIT_A] == !$past(pwm_out[0])));

    // R7
    pwm_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_sel |=> (pad_pd[PWM_BIT_B] == !$past(pwm_out[1])));

    for (genvar i = 0; i < WIDTH; i++) begin : g_pulse
        // R5
        spu_two_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pad_spu[i] && $past(pad_spu[i])) |=> !pad_spu[i]);
        // R5
        spu_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pad_spu[i]) |-> $past(pad_pd[i]));
    end
endmodule

bind quasi_port_ctrl quasi_port_chk #(
    .WIDTH(WIDTH), .PWM_BIT_A(PWM_BIT_A), .PWM_BIT_B(PWM_BIT_B)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .alt_out(alt_out),
    .pwm_sel(pwm_sel), .pwm_out(pwm_out), .pin_in(pin_in),
    .pin_sync(pin_sync), .pad_pd(pad_pd), .pad_spu(pad_spu),
    .pad_wpu(pad_wpu)
);

// File: tb/quasi_port_ctrl_bench.sv
module quasi_port_ctrl_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_sel = 1'b0;
    logic [W-1:0] rd_data;
    logic [W-1:0] alt_out = '1;
    logic         pwm_sel = 1'b0;
    logic [1:0]   pwm_out = 2'b00;
    logic [W-1:0] pin_in;
    logic [W-1:0] pin_sync;
    logic [W-1:0] pad_pd, pad_spu, pad_wpu;
    logic [W-1:0] ext_low = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    // pad model: low when pulled down inside or outside, else pulled up
    assign pin_in = ~pad_pd & ~ext_low;

    quasi_port_ctrl u_quasi_port_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .alt_out(alt_out),
        .pwm_sel(pwm_sel), .pwm_out(pwm_out), .pin_in(pin_in),
        .pin_sync(pin_sync), .pad_pd(pad_pd), .pad_spu(pad_spu),
        .pad_wpu(pad_wpu)
    );

    typedef enum int {S_RD, S_PD, S_SPU, S_WPU, S_SYNC} sig_e;
    typedef struct {
        string        tag;
        sig_e         sig;
        logic [W-1:0] exp;
    } item_t;

    item_t sb[$];

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_val(input string tag, input sig_e sig, input logic [W-1:0] exp);
        item_t it;
        it.tag = tag; it.sig = sig; it.exp = exp;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic write(input logic [W-1:0] v);
        wr_en = 1'b1; wr_data = v;
        tick(1);
        wr_en = 1'b0;
    endtask

    initial begin : monitor
        item_t it;
        logic [W-1:0] got;
        forever begin
            wait (sb.size() != 0);
            it = sb.pop_front();
            case (it.sig)
                S_RD:    got = rd_data;
                S_PD:    got = pad_pd;
                S_SPU:   got = pad_spu;
                S_WPU:   got = pad_wpu;
                default: got = pin_sync;
            endcase
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s sig=%s actual=%h expected=%h", it.tag, it.sig.name(), got, it.exp);
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        tick(3);
        expect_val("R1 latch in reset", S_RD, 8'hFF);
        rst_n = 1'b1;
        tick(2);
        expect_val("R1 latch", S_RD, 8'hFF);
        expect_val("R1 pd", S_PD, 8'h00);
        expect_val("R1 spu", S_SPU, 8'h00);
        expect_val("R1 wpu", S_WPU, 8'hFF);

        write(8'h5A);
        expect_val("R3 latch read", S_RD, 8'h5A);
        expect_val("R2 pd not yet", S_PD, 8'h00);
        tick(1);
        expect_val("R2 pd", S_PD, 8'hA5);
        expect_val("R2 wpu", S_WPU, 8'h5A);
        expect_val("R5 no pulse on fall", S_SPU, 8'h00);
        rd_sel = 1'b1;
        tick(1);
        expect_val("R4 one edge old", S_RD, 8'hFF);
        tick(1);
        expect_val("R4 pin read", S_RD, 8'h5A);
        rd_sel = 1'b0;

        write(8'hFF);
        tick(1);
        expect_val("R5 pulse c1", S_SPU, 8'hA5);
        expect_val("R5 pd off", S_PD, 8'h00);
        tick(1);
        expect_val("R5 pulse c2", S_SPU, 8'hA5);
        tick(1);
        expect_val("R5 pulse end", S_SPU, 8'h00);
        expect_val("R5 weak stays", S_WPU, 8'hFF);

        wr_en = 1'b1; wr_data = 8'h00;
        tick(1); wr_data = 8'hFF;
        tick(1); wr_data = 8'h00;
        tick(1); wr_en = 1'b0;
        expect_val("R5 short rise", S_SPU, 8'hFF);
        tick(1);
        expect_val("R5 cut spu", S_SPU, 8'h00);
        expect_val("R5 cut pd", S_PD, 8'hFF);

        write(8'hFF);
        tick(4);
        rd_sel = 1'b1;
        expect_val("R4 pins high", S_RD, 8'hFF);
        ext_low = 8'h01;
        tick(1);
        expect_val("R4 ext one edge", S_RD, 8'hFF);
        tick(1);
        expect_val("R4 ext seen", S_RD, 8'hFE);
        expect_val("R4 pin_sync", S_SYNC, 8'hFE);
        ext_low = 8'h00;
        rd_sel = 1'b0;
        tick(2);

        alt_out = 8'hFA;
        tick(1);
        expect_val("R6 alt merge and mask", S_PD, 8'h01);
        alt_out = 8'hFF;
        write(8'hFE);
        tick(1);
        expect_val("R6 latch 0 holds low", S_PD, 8'h01);
        write(8'hFF);
        tick(3);

        pwm_sel = 1'b1; pwm_out = 2'b01;
        write(8'h00);
        tick(1);
        expect_val("R7 pwm override", S_PD, 8'hF7);
        expect_val("R7 latch read", S_RD, 8'h00);
        pwm_out = 2'b10;
        tick(1);
        expect_val("R7 pwm swap", S_PD, 8'hEF);
        expect_val("R5 pwm rise pulse", S_SPU, 8'h10);
        pwm_sel = 1'b0;
        tick(1);
        expect_val("R7 pwm off", S_PD, 8'hFF);
        expect_val("R5 pulse cleared", S_SPU, 8'h00);
        pwm_out = 2'b11;
        tick(2);
        expect_val("R7 pwm ignored", S_PD, 8'hFF);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule